// File: doc/BRIEF.md
# Way-Lockable LRU Victim Selector

This block picks which way of a four-way set-associative cache receives the next line fill. The cache holds 16 KB in 32-byte lines, so there are 128 sets. For every set the block keeps a full least-recently-used ranking of the four ways in registers. A hit moves the way that hit to the most-recent position. A fill takes the least-recently-used way as its victim and then marks that way as most recent. The instruction cache and the data cache each use a separate instance, and the set index is taken from the physical address.

Software can lock the lowest-numbered ways so that their lines stay resident. A two-bit count gives how many ways are locked, from none up to three. A separate whole-cache lock bit takes priority over the count. When it is set, no way can be allocated: the block raises a no-allocate flag and leaves the ranking of the set as it was. Hits still update the ranking of locked ways. The tag and data arrays, bus transfers, coherency and write-back are not part of this block.

Top module: `way_lock_repl`

## Requirements
- R1: After reset, every set ranks way 0 as least recent and way 3 as most recent. Both registered outputs read 0: victim_way = 0 and no_alloc = 0.
- R2: When fill_req is 1, victim_way becomes the least-recently-used unlocked way of set set_idx. A hit with hit = 1 moves hit_way to the most-recent position of set_idx.
- R3: When a fill allocates a way, that victim way becomes the most-recent way of its set.
- R4: lock_cnt = N, with N from 0 to 3, locks ways 0 to N-1. A victim never comes from a locked way.
- R5: When lock_all = 1, a fill sets no_alloc = 1, keeps victim_way at its previous value and leaves the ranking of the set unchanged. Any fill with lock_all = 0 clears no_alloc to 0.
- R6: A hit on a locked way still makes that way the most recent.
- R7: victim_way and no_alloc change only on the clock edge that samples fill_req = 1. They are valid in the cycle that follows, and they hold their value in every cycle without a fill.
- R8: When a hit and a fill occur in the same cycle, the hit is applied first. The victim is then chosen from the ranking after the hit, and after that the victim is made most recent.
- R9: Each set keeps its own ranking. Activity on one set does not change the victim chosen in any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_idx | input | 7 | Set addressed by the hit and/or the fill |
| hit | input | 1 | A lookup in set_idx hit |
| hit_way | input | 2 | Way that hit |
| fill_req | input | 1 | Request a victim for a line fill in set_idx |
| lock_cnt | input | 2 | Number of locked ways, counted up from way 0 |
| lock_all | input | 1 | Lock the whole cache (no allocation) |
| victim_way | output | 2 | Registered victim for the last allocating fill |
| no_alloc | output | 1 | Registered: the last fill could not allocate |

## Verification
A hit and a fill can land in the same cycle and the same set, and the order in which they update the ranking then decides the victim. The bench provokes this by driving a hit on the least-recently-used way together with a fill. If the hit is applied first, as R8 requires, the victim is the next-oldest way. If the hit is ignored or applied after the choice, the old least-recently-used way comes out instead. The bench judges each such cycle against a reference recency list that it keeps for itself, applying the hit first and then the fill.

// File: rtl/cache_repl_pkg.sv
// Package: geometry defaults shared by the replacement selector.
// Assumes a power-of-two line size and way count.
package cache_repl_pkg;
    localparam int CACHE_BYTES = 16384;
    localparam int LINE_BYTES  = 32;
    localparam int NUM_WAYS    = 4;
    localparam int NUM_SETS    = CACHE_BYTES / (LINE_BYTES * NUM_WAYS);
    localparam int SET_BITS    = $clog2(NUM_SETS);
    localparam int WAY_BITS    = $clog2(NUM_WAYS);
endpackage

// File: rtl/repl_lock_mask.sv
// Turns the lock count and the whole-cache lock bit into a per-way lock mask.
// Assumes the count locks ways from way 0 upward.
module repl_lock_mask #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAY_W-1:0] lock_cnt,
    input  logic             lock_all,
    output logic [WAYS-1:0]  locked
);
    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_way
            // Way w is locked when it lies below the count or the whole cache is locked.
            assign locked[w] = lock_all || (w < int'(lock_cnt));
        end
    endgenerate
endmodule

// File: rtl/repl_victim_pick.sv
// Picks the oldest unlocked way from a set of per-way ages (larger = older).
// Assumes the ages form a permutation, so at most one way can win.
module repl_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic [WAYS-1:0]            locked,
    output logic [WAY_W-1:0]           victim,
    output logic                       none_free
);
    logic [WAYS-1:0] wins;

    // A way wins when it is unlocked and older than every other unlocked way.
    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            wins[i] = !locked[i];
            for (int j = 0; j < WAYS; j++) begin
                if (j != i && !locked[j] && !(ages[j] < ages[i])) begin
                    wins[i] = 1'b0;
                end
            end
        end
    end

    // Encode the winning way and flag the case where every way is locked.
    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (wins[i]) victim = WAY_W'(i);
        end
        none_free = &locked;
    end
endmodule

// File: rtl/repl_age_store.sv
// Register file holding one age vector per set; asynchronous read, one write per cycle.
// Assumes the writer always supplies a permutation of ages.
module repl_age_store #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int SETS  = 128,
    parameter int SET_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           set_idx,
    input  logic                       wr_en,
    input  logic [WAYS-1:0][WAY_W-1:0] wr_ages,
    output logic [WAYS-1:0][WAY_W-1:0] rd_ages
);
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] ages_q;
    logic [WAYS-1:0]                      seen;

    // Reset ranks way 0 oldest to the last way newest; otherwise write the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ages_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else if (wr_en) begin
            ages_q[set_idx] <= wr_ages;
        end
    end

    // Read port for the addressed set.
    assign rd_ages = ages_q[set_idx];

    // Collect which age values are present in the addressed set.
    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            seen[int'(rd_ages[w])] = 1'b1;
        end
    end

    // R2: a full LRU ranking needs each age exactly once in every set.
    p_age_permutation_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {WAYS{1'b1}});
endmodule

// File: rtl/way_lock_repl.sv
// Victim selector for a set-associative cache with a true-LRU ranking per set and way locking.
// Assumes at most one hit and one fill per cycle, both on set_idx; the hit is applied first.
module way_lock_repl
    import cache_repl_pkg::*;
#(
    parameter int WAYS  = NUM_WAYS,
    parameter int SETS  = NUM_SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_req,
    input  logic [WAY_W-1:0] lock_cnt,
    input  logic             lock_all,
    output logic [WAY_W-1:0] victim_way,
    output logic             no_alloc
);
    typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

    ages_t           rd_ages;
    ages_t           after_hit;
    ages_t           after_fill;
    logic [WAYS-1:0] locked;
    logic [WAY_W-1:0] pick;
    logic            none_free;
    logic            alloc;
    logic            wr_en;

    // Makes way w the newest; ways that were newer than w each age by one step.
    function automatic ages_t touch(ages_t a, logic [WAY_W-1:0] w);
        ages_t r;
        for (int i = 0; i < WAYS; i++) begin
            r[i] = (a[i] < a[w]) ? a[i] + WAY_W'(1) : a[i];
        end
        r[w] = '0;
        return r;
    endfunction

    repl_age_store #(.WAYS(WAYS), .WAY_W(WAY_W), .SETS(SETS), .SET_W(SET_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (set_idx),
        .wr_en   (wr_en),
        .wr_ages (after_fill),
        .rd_ages (rd_ages)
    );

    repl_lock_mask #(.WAYS(WAYS), .WAY_W(WAY_W)) u_mask (
        .lock_cnt (lock_cnt),
        .lock_all (lock_all),
        .locked   (locked)
    );

    repl_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
        .ages      (after_hit),
        .locked    (locked),
        .victim    (pick),
        .none_free (none_free)
    );

    // Apply the hit first, then promote the chosen victim when the fill allocates.
    always_comb begin
        after_hit  = hit ? touch(rd_ages, hit_way) : rd_ages;
        alloc      = fill_req && !none_free;
        after_fill = alloc ? touch(after_hit, pick) : after_hit;
        wr_en      = hit || alloc;
    end

    // Register the fill result; the victim holds when the fill cannot allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_way <= '0;
            no_alloc   <= 1'b0;
        end else if (fill_req) begin
            no_alloc <= none_free;
            if (!none_free) victim_way <= pick;
        end
    end

    // R4: an allocating fill never returns a way below the lock count.
    p_locked_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !lock_all |=> !no_alloc && (victim_way >= $past(lock_cnt)));

    // R5: whole-cache lock refuses allocation and keeps the old victim.
    p_all_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && lock_all |=> no_alloc && $stable(victim_way));

    // R7: outputs move only after a fill request.
    p_hold_no_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> $stable(victim_way) && $stable(no_alloc));

    // R6: a hit without a fill leaves the hit way newest, locked or not.
    p_hit_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !fill_req |=> (set_idx != $past(set_idx)) || (rd_ages[$past(hit_way)] == '0));

    // R3: the allocated way is newest in its set afterwards.
    p_fill_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !lock_all |=> (set_idx != $past(set_idx)) || (rd_ages[victim_way] == '0));
endmodule

// File: tb/test_way_lock_repl.sv
// Bench: vector table walked against a recency-list model, then directed cases.
module test_way_lock_repl;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 128;

    typedef struct packed {
        logic [6:0] s;
        logic       h;
        logic [1:0] hw;
        logic       f;
        logic [1:0] n;
        logic       a;
    } vec_t;

    localparam int NV = 22;
    // Columns: set, hit, hit_way, fill, lock count, lock all.
    localparam vec_t VEC [NV] = '{
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R1 fresh set gives way 0
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R3 filled way became newest
        {7'd3,   1'b1, 2'd0, 1'b0, 2'd0, 1'b0},  // R2 hit reorders, R7 hold
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R2
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R2
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R2
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd2, 1'b0},  // R4 two ways locked
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd2, 1'b0},  // R4
        {7'd3,   1'b1, 2'd0, 1'b0, 2'd3, 1'b0},  // R6 hit on locked way
        {7'd3,   1'b0, 2'd0, 1'b1, 2'd3, 1'b0},  // R4 only way 3 free
        {7'd9,   1'b1, 2'd0, 1'b1, 2'd0, 1'b0},  // R8 hit on oldest plus fill
        {7'd9,   1'b1, 2'd1, 1'b1, 2'd0, 1'b0},  // R8
        {7'd9,   1'b0, 2'd0, 1'b1, 2'd0, 1'b1},  // R5 whole-cache lock
        {7'd9,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R5 state unchanged
        {7'd9,   1'b0, 2'd0, 1'b1, 2'd1, 1'b0},  // R4 one way locked
        {7'd127, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0},  // R9 top set
        {7'd0,   1'b1, 2'd3, 1'b0, 2'd0, 1'b0},  // R9 set 0 hit
        {7'd127, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R9
        {7'd0,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R9
        {7'd0,   1'b1, 2'd1, 1'b1, 2'd1, 1'b1},  // R5 hit still applies under full lock
        {7'd0,   1'b0, 2'd0, 1'b1, 2'd0, 1'b0},  // R6 R5
        {7'd3,   1'b1, 2'd2, 1'b1, 2'd3, 1'b0}   // R8 with lock
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] set_idx = '0;
    logic       hit = 1'b0;
    logic [1:0] hit_way = '0;
    logic       fill_req = 1'b0;
    logic [1:0] lock_cnt = '0;
    logic       lock_all = 1'b0;
    logic [1:0] victim_way;
    logic       no_alloc;

    int checks = 0;
    int errors = 0;
    int ord [NSETS][4];  // per set: index 0 oldest .. index 3 newest
    logic [1:0] exp_v = '0;
    logic       exp_n = 1'b0;

    way_lock_repl i_way_lock_repl (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit(hit), .hit_way(hit_way),
        .fill_req(fill_req), .lock_cnt(lock_cnt), .lock_all(lock_all),
        .victim_way(victim_way), .no_alloc(no_alloc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_reset();
        for (int s = 0; s < NSETS; s++)
            for (int k = 0; k < 4; k++) ord[s][k] = k;
    endtask

    task automatic model_touch(int s, int w);
        int pos = 0;
        for (int k = 0; k < 4; k++) if (ord[s][k] == w) pos = k;
        for (int k = pos; k < 3; k++) ord[s][k] = ord[s][k+1];
        ord[s][3] = w;
    endtask

    task automatic check(string req, logic [1:0] v, logic n);
        checks++;
        if (victim_way !== v || no_alloc !== n) begin
            errors++;
            $display("FAIL %s: victim=%0d no_alloc=%0b, expected victim=%0d no_alloc=%0b",
                     req, victim_way, no_alloc, v, n);
        end
    endtask

    task automatic step(vec_t x, string req);
        int s = int'(x.s);
        if (x.h) model_touch(s, int'(x.hw));
        if (x.f) begin
            if (x.a) exp_n = 1'b1;
            else begin
                exp_n = 1'b0;
                for (int k = 3; k >= 0; k--)
                    if (ord[s][k] >= int'(x.n)) exp_v = 2'(ord[s][k]);
                model_touch(s, int'(exp_v));
            end
        end
        @(negedge clk);
        set_idx = x.s; hit = x.h; hit_way = x.hw; fill_req = x.f;
        lock_cnt = x.n; lock_all = x.a;
        @(negedge clk);
        hit = 1'b0; fill_req = 1'b0;
        check(req, exp_v, exp_n);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) step(VEC[i], $sformatf("R2/table row %0d", i));

        // R7: idle cycles leave the outputs alone.
        repeat (3) @(negedge clk);
        check("R7 hold while idle", exp_v, exp_n);

        // R5: full lock on a fresh set, then the order must still be the reset order.
        step('{s:7'd50, h:1'b0, hw:2'd0, f:1'b1, n:2'd0, a:1'b1}, "R5 full lock refuses");
        step('{s:7'd50, h:1'b0, hw:2'd0, f:1'b1, n:2'd0, a:1'b0}, "R5 ranking untouched");

        // R1: a mid-run reset restores every set's order and clears the outputs.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset(); exp_v = 2'd0; exp_n = 1'b0;
        check("R1 outputs after reset", 2'd0, 1'b0);
        step('{s:7'd3, h:1'b0, hw:2'd0, f:1'b1, n:2'd0, a:1'b0}, "R1 order after reset");
        step('{s:7'd3, h:1'b1, hw:2'd1, f:1'b1, n:2'd0, a:1'b0}, "R8 hit first after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule